// File: doc/BRIEF.md
# Mantissa-Exponent Serial Clock Generator

This block derives the serial clock of an SPI master from the core clock. A single configuration byte selects the division ratio as a 4-bit mantissa times a power of two from 1 to 128. The ratio therefore runs from 2 up to 1920 core cycles per serial clock period. The block drives the serial clock level. It also produces two strobes, each one core cycle wide. These mark the cycle in which the serial clock has just gone high or just gone low, so that neighbouring shift logic can launch and capture data without detecting edges itself.

Each serial clock period is a low phase followed by a high phase. A new ratio is latched only as the clock falls, or while the block is disabled. A configuration write therefore never shortens or stretches a phase that has already started. While the enable is low, the clock rests low and the phase counter is cleared. After the enable rises, the first period is always a complete one.

Top module: `sck_ratio_gen`

## Requirements
- R1: The period of sckOut is N core cycles, where N = mantissa × 2^exponent. The mantissa is cfgByte[3:0]. The exponent is a 3-bit value whose bit 0 is cfgByte[4] and whose bits 2:1 are cfgByte[7:6].
- R2: cfgByte[5] has no effect on the period or on the phase lengths.
- R3: When mantissa × 2^exponent is below 2 (a mantissa of 0, or a mantissa of 1 with an exponent of 0), the block uses N = 2, so sckOut keeps toggling.
- R4: Within each period, sckOut is low for ceil(N/2) core cycles and then high for floor(N/2) core cycles.
- R5: riseStrobe is high for exactly the first core cycle in which sckOut is high after being low. fallStrobe is high for exactly the first core cycle in which sckOut is low after being high. The two strobes are never high together.
- R6: While enable is low, sckOut is low from the next cycle on and riseStrobe stays low. fallStrobe pulses once only if sckOut was high when enable dropped. The phase counter is cleared, so once enable is sampled high, sckOut rises on the ceil(N/2)-th clock edge that samples enable high.
- R7: A cfgByte change is taken in only at the clock edge where sckOut falls. The low and high phases already under way keep their old lengths, and the following period uses the new N.
- R8: While rstN is low, sckOut, riseStrobe and fallStrobe are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the serial clock when high; idles it low when low |
| cfgByte | input | 8 | Ratio setting: mantissa in bits 3:0, exponent bits in 4, 7 and 6 |
| sckOut | output | 1 | Serial clock level |
| riseStrobe | output | 1 | One-cycle pulse in the first cycle sckOut is high |
| fallStrobe | output | 1 | One-cycle pulse in the first cycle sckOut is low |

## Verification
The assertions assume that rstN is released synchronously and that enable and cfgByte change only between clock edges. The bench keeps to this by driving every input on the falling edge of the core clock. The strobe properties also assume that sckOut has no other driver, so that every level change is one the block made. The directed stimulus changes cfgByte in both the first low cycle and the first high cycle of a period, which exercises the latch-at-fall rule from both sides. It drops enable in the middle of a high phase, so that the forced fall and the cleared counter can be seen at the ports.

// File: rtl/sckdiv_pkg.sv
package sckdiv_pkg;
  localparam int CFG_W      = 8;
  localparam int MANT_W     = 4;
  localparam int EXP_W      = 3;
  localparam int EXP_LO_POS = 4;
  localparam int EXP_HI_POS = 6;
  localparam int MIN_RATIO  = 2;
  localparam int RATIO_W    = MANT_W + (1 << EXP_W) - 1;

  typedef struct packed {
    logic forceIdle;
    logic cntClear;
    logic cntStep;
    logic goHigh;
    logic goLow;
  } seqStrobes_t;
endpackage

// File: rtl/ckdiv_decode.sv
module ckdiv_decode #(
  parameter int CFG_W      = sckdiv_pkg::CFG_W,
  parameter int MANT_W     = sckdiv_pkg::MANT_W,
  parameter int EXP_W      = sckdiv_pkg::EXP_W,
  parameter int EXP_LO_POS = sckdiv_pkg::EXP_LO_POS,
  parameter int EXP_HI_POS = sckdiv_pkg::EXP_HI_POS,
  parameter int MIN_RATIO  = sckdiv_pkg::MIN_RATIO,
  parameter int RATIO_W    = MANT_W + (1 << EXP_W) - 1
) (
  input  logic [CFG_W-1:0]   cfgByte,
  output logic [RATIO_W-1:0] lowLen,
  output logic [RATIO_W-1:0] highLen
);
  logic [MANT_W-1:0]  mant;
  logic [EXP_W-1:0]   expVal;
  logic [RATIO_W-1:0] rawRatio;
  logic [RATIO_W-1:0] ratio;

  assign mant = cfgByte[MANT_W-1:0];

  // The exponent is split: its lowest bit sits apart from the upper bits.
  generate
    if (EXP_W > 1) begin : g_split_exp
      assign expVal = {cfgByte[EXP_HI_POS +: EXP_W-1], cfgByte[EXP_LO_POS]};
    end else begin : g_single_exp
      assign expVal = cfgByte[EXP_LO_POS];
    end
  endgenerate

  always_comb begin
    rawRatio = RATIO_W'(mant) << expVal;
    ratio    = (rawRatio < RATIO_W'(MIN_RATIO)) ? RATIO_W'(MIN_RATIO) : rawRatio;
    highLen  = ratio >> 1;
    lowLen   = ratio - highLen;
  end
endmodule

// File: rtl/ckdiv_ctrl.sv
module ckdiv_ctrl #(
  parameter int RATIO_W = sckdiv_pkg::RATIO_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic [RATIO_W-1:0]      lowLenIn,
  input  logic [RATIO_W-1:0]      highLenIn,
  input  logic                    sckLevel,
  input  logic [RATIO_W-1:0]      cnt,
  output sckdiv_pkg::seqStrobes_t seq
);
  logic [RATIO_W-1:0] lowLenQ;
  logic [RATIO_W-1:0] highLenQ;
  logic               lastLow;
  logic               lastHigh;
  logic               loadLen;

  assign lastLow  = (cnt == lowLenQ  - RATIO_W'(1));
  assign lastHigh = (cnt == highLenQ - RATIO_W'(1));

  always_comb begin
    seq = '0;
    if (!enable) begin
      seq.forceIdle = 1'b1;
    end else if (!sckLevel) begin
      if (lastLow) begin
        seq.goHigh   = 1'b1;
        seq.cntClear = 1'b1;
      end else begin
        seq.cntStep  = 1'b1;
      end
    end else begin
      if (lastHigh) begin
        seq.goLow    = 1'b1;
        seq.cntClear = 1'b1;
      end else begin
        seq.cntStep  = 1'b1;
      end
    end
  end

  // A new setting is adopted only at a period boundary or while idle.
  assign loadLen = seq.forceIdle | seq.goLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowLenQ  <= RATIO_W'(1);
      highLenQ <= RATIO_W'(1);
    end else if (loadLen) begin
      lowLenQ  <= lowLenIn;
      highLenQ <= highLenIn;
    end
  end
endmodule

// File: rtl/ckdiv_dpath.sv
module ckdiv_dpath #(
  parameter int RATIO_W = sckdiv_pkg::RATIO_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  sckdiv_pkg::seqStrobes_t seq,
  output logic [RATIO_W-1:0]      cnt,
  output logic                    sckLevel,
  output logic                    riseQ,
  output logic                    fallQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      sckLevel <= 1'b0;
      riseQ    <= 1'b0;
      fallQ    <= 1'b0;
    end else begin
      riseQ <= seq.goHigh;
      fallQ <= seq.goLow | (seq.forceIdle & sckLevel);
      if (seq.forceIdle || seq.goLow) begin
        sckLevel <= 1'b0;
      end else if (seq.goHigh) begin
        sckLevel <= 1'b1;
      end
      if (seq.forceIdle || seq.cntClear) begin
        cnt <= '0;
      end else if (seq.cntStep) begin
        cnt <= cnt + RATIO_W'(1);
      end
    end
  end
endmodule

// File: rtl/sck_ratio_gen.sv
module sck_ratio_gen #(
  parameter int CFG_W   = sckdiv_pkg::CFG_W,
  parameter int MANT_W  = sckdiv_pkg::MANT_W,
  parameter int EXP_W   = sckdiv_pkg::EXP_W,
  parameter int RATIO_W = MANT_W + (1 << EXP_W) - 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [CFG_W-1:0] cfgByte,
  output logic             sckOut,
  output logic             riseStrobe,
  output logic             fallStrobe
);
  logic [RATIO_W-1:0]      lowLen;
  logic [RATIO_W-1:0]      highLen;
  logic [RATIO_W-1:0]      cnt;
  logic                    sckLevel;
  sckdiv_pkg::seqStrobes_t seq;

  ckdiv_decode #(
    .CFG_W(CFG_W), .MANT_W(MANT_W), .EXP_W(EXP_W), .RATIO_W(RATIO_W)
  ) u_decode (
    .cfgByte(cfgByte),
    .lowLen (lowLen),
    .highLen(highLen)
  );

  ckdiv_ctrl #(.RATIO_W(RATIO_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .lowLenIn (lowLen),
    .highLenIn(highLen),
    .sckLevel (sckLevel),
    .cnt      (cnt),
    .seq      (seq)
  );

  ckdiv_dpath #(.RATIO_W(RATIO_W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .seq     (seq),
    .cnt     (cnt),
    .sckLevel(sckLevel),
    .riseQ   (riseStrobe),
    .fallQ   (fallStrobe)
  );

  assign sckOut = sckLevel;
endmodule

// File: rtl/sck_ratio_gen_chk.sv
module sck_ratio_gen_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic sckOut,
  input logic riseStrobe,
  input logic fallStrobe
);
  // R5: the rise strobe marks exactly the first high cycle
  p_rise_tracks_r5: assert property (@(posedge clk) disable iff (!rstN)
    riseStrobe == $rose(sckOut));

  // R5: the fall strobe marks exactly the first low cycle
  p_fall_tracks_r5: assert property (@(posedge clk) disable iff (!rstN)
    fallStrobe == $fell(sckOut));

  // R5: both strobes never fire together
  p_one_edge_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(riseStrobe && fallStrobe));

  // R6: disabled means the clock idles low with no rise
  p_idle_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!sckOut && !riseStrobe));

  // R8: outputs quiet during reset
  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_quiet_r8: assert (!sckOut && !riseStrobe && !fallStrobe);
    end
  end
endmodule

bind sck_ratio_gen sck_ratio_gen_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .sckOut    (sckOut),
  .riseStrobe(riseStrobe),
  .fallStrobe(fallStrobe)
);

// File: tb/sim_sck_ratio_gen.sv
module sim_sck_ratio_gen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [7:0] cfgByte = 8'h00;
  logic       sckOut, riseStrobe, fallStrobe;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;
  logic sS, sR, sF;

  sck_ratio_gen u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgByte(cfgByte),
    .sckOut(sckOut), .riseStrobe(riseStrobe), .fallStrobe(fallStrobe)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      nFail = nFail + 1;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks = nChecks + 1;
    if (!ok) begin
      nFail = nFail + 1;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic sample();
    @(negedge clk);
    sS = sckOut; sR = riseStrobe; sF = fallStrobe;
  endtask

  // Leaves the current sample on the first low cycle after a fall.
  task automatic waitFall(input string req);
    int n = 0;
    do begin
      sample();
      n++;
    end while (!(sS == 1'b0 && sF == 1'b1) && n < 5000);
    check(n < 5000, req, "fall seen", n, 0);
  endtask

  // Current sample is the first of a run at 'level'; returns its length.
  task automatic runLen(input logic level, output int n, output int extra);
    n = 1; extra = 0;
    forever begin
      sample();
      if (sS != level || n > 4000) break;
      n++;
      if (sR || sF) extra++;
    end
  endtask

  task automatic measure(input int expL, input int expH, input string req);
    int n, extra;
    runLen(1'b0, n, extra);
    check(n == expL, req, "low phase", n, expL);
    check(sR == 1'b1 && sF == 1'b0 && extra == 0, "R5", "rise strobe", sR, 1);
    runLen(1'b1, n, extra);
    check(n == expH, req, "high phase", n, expH);
    check(sF == 1'b1 && sR == 1'b0 && extra == 0, "R5", "fall strobe", sF, 1);
  endtask

  task automatic applyCfg(input logic [7:0] c, input int expL, input int expH,
                          input string req);
    cfgByte = c;
    waitFall(req);
    measure(expL, expH, req);
  endtask

  task automatic testReset();
    sample();
    check(!sS && !sR && !sF, "R8", "outputs in reset", {sS, sR, sF}, 0);
    rstN = 1'b1;
    sample();
    check(!sS && !sR && !sF, "R8", "idle after reset", {sS, sR, sF}, 0);
  endtask

  task automatic testStart();
    cfgByte = 8'h05;            // N=5 -> low 3, high 2
    repeat (3) sample();
    enable = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      sample();
      check(sS == (k == 3) && sR == (k == 3), "R6", "first rise position",
            sS, (k == 3));
    end
  endtask

  task automatic testRatios();
    applyCfg(8'h05, 3, 2, "R4");       // 5 odd
    applyCfg(8'h09, 5, 4, "R4");       // 9 odd
    applyCfg(8'h13, 3, 3, "R1");       // 3<<1
    applyCfg(8'h42, 4, 4, "R1");       // 2<<2 (exp bit1 from byte bit6)
    applyCfg(8'h82, 16, 16, "R1");     // 2<<4 (exp bit2 from byte bit7)
    applyCfg(8'h55, 20, 20, "R1");     // 5<<3
    applyCfg(8'hD7, 448, 448, "R1");   // 7<<7
    applyCfg(8'hD1, 64, 64, "R3");     // mantissa 1 with exponent is not clamped
  endtask

  task automatic testIgnoredBit();
    applyCfg(8'h15, 5, 5, "R2");       // 5<<1
    applyCfg(8'h35, 5, 5, "R2");       // same with byte bit5 set
  endtask

  task automatic testClamp();
    applyCfg(8'h00, 1, 1, "R3");
    applyCfg(8'h01, 1, 1, "R3");
    applyCfg(8'hC0, 1, 1, "R3");
  endtask

  task automatic testChangeMidHigh();
    int n, extra;
    applyCfg(8'h15, 5, 5, "R7");
    do sample(); while (!sR);          // first high cycle of ratio 10
    cfgByte = 8'h04;                   // N=4 -> 2/2
    runLen(1'b1, n, extra);
    check(n == 5, "R7", "high kept old length", n, 5);
    measure(2, 2, "R7");
  endtask

  task automatic testChangeMidLow();
    applyCfg(8'h04, 2, 2, "R7");       // ends on first low sample
    cfgByte = 8'h09;                   // N=9 -> 5/4
    measure(2, 2, "R7");
    measure(5, 4, "R7");
  endtask

  task automatic testDisableMidHigh();
    int bad = 0;
    applyCfg(8'h55, 20, 20, "R6");
    do sample(); while (!sR);
    sample();
    enable = 1'b0;
    sample();
    check(!sS && sF && !sR, "R6", "forced fall", sF, 1);
    for (int k = 0; k < 10; k++) begin
      sample();
      if (sS || sR || sF) bad++;
    end
    check(bad == 0, "R6", "idle cycles busy", bad, 0);
    cfgByte = 8'h05;
    sample();
    enable = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      sample();
      check(sS == (k == 3) && sR == (k == 3), "R6", "restart from zero",
            sS, (k == 3));
    end
  endtask

  initial begin
    testReset();
    testStart();
    testRatios();
    testIgnoredBit();
    testClamp();
    testChangeMidHigh();
    testChangeMidLow();
    testDisableMidHigh();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule